// File: doc/BRIEF.md
# Data Watchpoint Unit

The unit watches the data-side memory accesses of a processor core and raises a break request when an access touches a programmed, 8-byte aligned block. Two independent channels are provided. Each channel has a block address, a 64-bit per-byte ignore mask and a 3-bit access-mode field. When a channel matches, it sets its own sticky bit in a cause register. Software reads that register to learn which channel fired and writes it to acknowledge the break.

Configuration goes through a flat register port: one write strobe with address and data, and a read-data output that is driven combinationally from the register address. The access-monitor input presents one access per cycle, made of a valid flag, the address, eight byte enables and the direction.

Top module: `dwatch_unit`

## Requirements
- R1: After reset every register reads zero, `brk_req` is low and both channels are disabled.
- R2: A channel block address register drops the low three bits of the written value, so they read as zero. Matching compares access address bits 31:3 only, so accesses at any offset inside the block can match.
- R3: Byte enable `acc_be[i]` selects byte offset i of the block. The high mask register covers offsets 0..3, with offset 0 in bits 31:24. The low mask register covers offsets 4..7, with offset 4 in bits 31:24. A lane is watched only when its mask byte is exactly 0x00. A hit needs at least one enabled byte on a watched lane.
- R4: The control register holds channel 0's mode in bits 2:0 and channel 1's mode in bits 5:3. Bits 31:6 read zero. Mode bit 1 permits writes and mode bit 2 permits reads, so the codes are 0 = off, 2 = writes, 4 = reads and 6 = any access. Mode bit 0 has no effect.
- R5: A hit on channel 0 sets cause bit 4 and a hit on channel 1 sets cause bit 5, at the clock edge that samples the access. Each bit stays set while the cause register is not written.
- R6: A write to the cause register replaces bits 5:0 with the written data, so writing zero clears it. A hit in the same cycle still sets its bit.
- R7: Cause bits 3:0 are software-held instruction-break flags. Writing them stores the value and raises no break request.
- R8: `brk_req` is high for exactly the one cycle after each cycle that carries a hit on any channel.
- R9: When both channels hit on the same access, both cause bits 4 and 5 are set.
- R10: An access with `acc_valid` low never hits, whatever its address, byte enables or direction.
- R11: The register addresses are 0 for control, 1 for cause, 2/3/4 for channel 0 (block address, high mask, low mask) and 5/6/7 for channel 1 (same order). All other addresses read zero. A register write takes effect at the clock edge, so an access in the same cycle is matched against the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_be | input | 8 | Access byte enables, bit i = offset i |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| brk_req | output | 1 | One-cycle break request |

## Verification
Accesses are aimed at the programmed block at varied offsets, at the next block up and at a far block. This separates a correct bit 31:3 compare from one that also looks at the low bits or at too few bits. Single-lane byte enables are swept against masks that open only one offset in each half, and against a mask byte of 0x01, which pins down the big-endian lane order and the exact-zero rule. Every mode code is tried with reads and with writes, and both channels are pointed at the same block. A cause clear, a config write and an access are also made to land in the same cycle, which shows that a hit wins over a clear and that matching uses the old settings. A behavioural model of all registers is compared with the read port and with `brk_req` on every cycle.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  // Mode field layout, per channel
  localparam int MODE_W = 3;
  localparam int WR_BIT = 1;
  localparam int RD_BIT = 2;
  // Register index map
  localparam int RA_CTRL      = 0;
  localparam int RA_CAUSE     = 1;
  localparam int RA_CH_BASE   = 2;
  localparam int RA_CH_STRIDE = 3;
  localparam int RA_OFS_BLK   = 0;
  localparam int RA_OFS_MHI   = 1;
  localparam int RA_OFS_MLO   = 2;

  function automatic int ch_reg(input int ch, input int ofs);
    return RA_CH_BASE + RA_CH_STRIDE * ch + ofs;
  endfunction
endpackage

// File: rtl/dwatch_match.sv
module dwatch_match #(
  parameter int BLK_W = 29,
  parameter int LANES = 8
) (
  input  logic               wr_ok,
  input  logic               rd_ok,
  input  logic [BLK_W-1:0]   blk_cfg,
  input  logic [LANES*8-1:0] mask,
  input  logic               acc_valid,
  input  logic [BLK_W-1:0]   acc_blk,
  input  logic [LANES-1:0]   acc_be,
  input  logic               acc_write,
  output logic               hit
);
  localparam int MASK_W = LANES * 8;

  logic [LANES-1:0] lane_live;
  logic             dir_ok;

  // Offset 0 sits in the most significant mask byte
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_live[i] = acc_be[i] && (mask[MASK_W-1-8*i -: 8] == 8'h00);
  end

  assign dir_ok = acc_write ? wr_ok : rd_ok;
  assign hit    = acc_valid && dir_ok && (acc_blk == blk_cfg) && (|lane_live);
endmodule

// File: rtl/dwatch_cause.sv
module dwatch_cause #(
  parameter  int NUM_IB = 4,
  parameter  int NUM_CH = 2,
  localparam int CW     = NUM_IB + NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_val,
  input  logic [NUM_CH-1:0] hit,
  output logic [CW-1:0]     cause_q,
  output logic              brk_req
);
  logic [CW-1:0] cause_d;
  logic          cause_en;
  logic          brk_d;

  always_comb begin
    cause_en = wr_en || (|hit);
    cause_d  = (wr_en ? wr_val : cause_q) | {hit, {NUM_IB{1'b0}}};
    brk_d    = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      brk_req <= 1'b0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      brk_req <= brk_d;
    end
  end
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int NUM_CH = 2,
  parameter  int NUM_IB = 4,
  parameter  int RA_W   = 4,
  localparam int LANES  = 2 * DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [DATA_W-1:0] acc_addr,
  input  logic [LANES-1:0]  acc_be,
  input  logic              acc_write,
  output logic              brk_req
);
  localparam int OFS_W  = $clog2(LANES);
  localparam int BLK_W  = DATA_W - OFS_W;
  localparam int CTRL_W = MODE_W * NUM_CH;
  localparam int CW     = NUM_IB + NUM_CH;

  logic [CTRL_W-1:0]             ctrl_q, ctrl_d;
  logic                          ctrl_we;
  logic                          cause_we;
  logic [CW-1:0]                 cause_q;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_rd;

  // Shared control register
  always_comb begin
    ctrl_we  = reg_we && (reg_addr == RA_W'(RA_CTRL));
    cause_we = reg_we && (reg_addr == RA_W'(RA_CAUSE));
    ctrl_d   = reg_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  // Per-channel configuration and comparator
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int I_BLK = ch_reg(c, RA_OFS_BLK);
    localparam int I_MHI = ch_reg(c, RA_OFS_MHI);
    localparam int I_MLO = ch_reg(c, RA_OFS_MLO);

    logic [BLK_W-1:0]  blk_q;
    logic [DATA_W-1:0] mhi_q, mlo_q;
    logic              we_blk, we_mhi, we_mlo;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
      we_blk = reg_we && (reg_addr == RA_W'(I_BLK));
      we_mhi = reg_we && (reg_addr == RA_W'(I_MHI));
      we_mlo = reg_we && (reg_addr == RA_W'(I_MLO));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blk_q <= '0;
        mhi_q <= '0;
        mlo_q <= '0;
      end else begin
        if (we_blk) blk_q <= reg_wdata[DATA_W-1:OFS_W];
        if (we_mhi) mhi_q <= reg_wdata;
        if (we_mlo) mlo_q <= reg_wdata;
      end
    end

    always_comb begin
      rd_val = '0;
      if (reg_addr == RA_W'(I_BLK)) rd_val = {blk_q, {OFS_W{1'b0}}};
      if (reg_addr == RA_W'(I_MHI)) rd_val = mhi_q;
      if (reg_addr == RA_W'(I_MLO)) rd_val = mlo_q;
    end
    assign ch_rd[c] = rd_val;

    dwatch_match #(
      .BLK_W (BLK_W),
      .LANES (LANES)
    ) u_match (
      .wr_ok     (ctrl_q[MODE_W*c+WR_BIT]),
      .rd_ok     (ctrl_q[MODE_W*c+RD_BIT]),
      .blk_cfg   (blk_q),
      .mask      ({mhi_q, mlo_q}),
      .acc_valid (acc_valid),
      .acc_blk   (acc_addr[DATA_W-1:OFS_W]),
      .acc_be    (acc_be),
      .acc_write (acc_write),
      .hit       (hit[c])
    );
  end

  dwatch_cause #(
    .NUM_IB (NUM_IB),
    .NUM_CH (NUM_CH)
  ) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cause_we),
    .wr_val  (reg_wdata[CW-1:0]),
    .hit     (hit),
    .cause_q (cause_q),
    .brk_req (brk_req)
  );

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_W'(RA_CTRL))  reg_rdata = DATA_W'(ctrl_q);
    if (reg_addr == RA_W'(RA_CAUSE)) reg_rdata = DATA_W'(cause_q);
    for (int c = 0; c < NUM_CH; c++) reg_rdata = reg_rdata | ch_rd[c];
  end
endmodule

// File: rtl/dwatch_unit_chk.sv
module dwatch_unit_chk
  import dwatch_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int NUM_CH = 2,
  parameter  int NUM_IB = 4,
  parameter  int RA_W   = 4,
  localparam int CTRL_W = MODE_W * NUM_CH,
  localparam int CW     = NUM_IB + NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [RA_W-1:0]   reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              acc_valid,
  input logic              brk_req,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CW-1:0]     cause_q
);
  logic cause_wr;
  logic any_on;

  always_comb begin
    cause_wr = reg_we && (reg_addr == RA_W'(RA_CAUSE));
    any_on   = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      any_on = any_on | ctrl_q[MODE_W*c+WR_BIT] | ctrl_q[MODE_W*c+RD_BIT];
  end

  // R8
  brk_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (cause_q[CW-1:NUM_IB] != '0));

  // R5
  sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R6
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && reg_wdata == '0 && !acc_valid) |=> (cause_q == '0));

  // R10
  idle_no_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !brk_req);

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_on |=> !brk_req);

  // R4
  always @(negedge clk) begin
    if (rst_n && reg_addr == RA_W'(RA_CTRL))
      ctrl_readback_chk: assert (reg_rdata == DATA_W'(ctrl_q))
        else $error("control readback mismatch");
  end
endmodule

bind dwatch_unit dwatch_unit_chk #(
  .DATA_W (DATA_W),
  .NUM_CH (NUM_CH),
  .NUM_IB (NUM_IB),
  .RA_W   (RA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .acc_valid (acc_valid),
  .brk_req   (brk_req),
  .ctrl_q    (ctrl_q),
  .cause_q   (cause_q)
);

// File: tb/dwatch_unit_test.sv
module dwatch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [7:0]  acc_be;
  logic        acc_write;
  logic        brk_req;

  always #5 clk = ~clk;

  dwatch_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_write(acc_write), .brk_req(brk_req)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string phase = "R1";

  // Behavioural reference state
  logic [31:0] m_ctrl, m_cause;
  logic        m_brk;
  logic [31:0] m_addr [2];
  logic [31:0] m_mh [2];
  logic [31:0] m_ml [2];

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return m_cause;
      4'd2: return m_addr[0];
      4'd3: return m_mh[0];
      4'd4: return m_ml[0];
      4'd5: return m_addr[1];
      4'd6: return m_mh[1];
      4'd7: return m_ml[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit m_hit(input int c);
    int mode, lane_byte;
    bit allowed;
    mode = int'((m_ctrl >> (3 * c)) & 32'h7);
    allowed = acc_write ? ((mode / 2) % 2 == 1) : ((mode / 4) % 2 == 1);
    if (!acc_valid || !allowed) return 0;
    if ((acc_addr >> 3) != (m_addr[c] >> 3)) return 0;
    for (int i = 0; i < 8; i++) begin
      if (i < 4) lane_byte = int'((m_mh[c] >> (8 * (3 - i))) & 32'hFF);
      else       lane_byte = int'((m_ml[c] >> (8 * (7 - i))) & 32'hFF);
      if (acc_be[i] && lane_byte == 0) return 1;
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [31:0] n_ctrl, n_cause;
    logic [31:0] n_addr [2];
    logic [31:0] n_mh [2];
    logic [31:0] n_ml [2];
    bit h0, h1;
    h0 = 0; h1 = 0;
    n_ctrl = m_ctrl; n_cause = m_cause;
    for (int c = 0; c < 2; c++) begin
      n_addr[c] = m_addr[c]; n_mh[c] = m_mh[c]; n_ml[c] = m_ml[c];
    end
    if (!rst_n) begin
      n_ctrl = 0; n_cause = 0;
      for (int c = 0; c < 2; c++) begin n_addr[c] = 0; n_mh[c] = 0; n_ml[c] = 0; end
    end else begin
      h0 = m_hit(0);
      h1 = m_hit(1);
      if (reg_we) begin
        case (reg_addr)
          4'd0: n_ctrl = reg_wdata & 32'h3F;
          4'd1: n_cause = reg_wdata & 32'h3F;
          4'd2: n_addr[0] = reg_wdata & ~32'h7;
          4'd3: n_mh[0] = reg_wdata;
          4'd4: n_ml[0] = reg_wdata;
          4'd5: n_addr[1] = reg_wdata & ~32'h7;
          4'd6: n_mh[1] = reg_wdata;
          4'd7: n_ml[1] = reg_wdata;
          default: ;
        endcase
      end
      if (h0) n_cause = n_cause | 32'h10;
      if (h1) n_cause = n_cause | 32'h20;
    end
    @(posedge clk);
    #1;
    m_ctrl = n_ctrl; m_cause = n_cause; m_brk = h0 | h1;
    for (int c = 0; c < 2; c++) begin
      m_addr[c] = n_addr[c]; m_mh[c] = n_mh[c]; m_ml[c] = n_ml[c];
    end
    @(negedge clk);
    chk({phase, " brk_req"}, {31'h0, brk_req}, {31'h0, m_brk});
    chk({phase, " rdata"}, reg_rdata, m_read(reg_addr));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [7:0] be, input logic w);
    acc_valid = 1'b1; acc_addr = a; acc_be = be; acc_write = w;
    tick();
    acc_valid = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    tick();
    chk(tag, reg_rdata, e);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_ctrl = 0; m_cause = 0; m_brk = 0;
    for (int c = 0; c < 2; c++) begin m_addr[c] = 0; m_mh[c] = 0; m_ml[c] = 0; end
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 4'd0; reg_wdata = 32'h0;
    acc_valid = 1'b0; acc_addr = 32'h0; acc_be = 8'h0; acc_write = 1'b0;

    // R1: reset state
    phase = "R1";
    tick();
    for (int a = 0; a < 8; a++) expect_reg(4'(a), 32'h0, "R1 reset value");
    chk("R1 brk_req low", {31'h0, brk_req}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R11: register map
    phase = "R11";
    wr(4'd2, 32'hDEAD_BEEF);
    expect_reg(4'd2, 32'hDEAD_BEE8, "R2 low address bits read zero");
    wr(4'd3, 32'h1234_5678);
    expect_reg(4'd3, 32'h1234_5678, "R11 ch0 high mask");
    wr(4'd7, 32'hCAFE_F00D);
    expect_reg(4'd7, 32'hCAFE_F00D, "R11 ch1 low mask");
    expect_reg(4'd9, 32'h0, "R11 unmapped reads zero");
    expect_reg(4'd15, 32'h0, "R11 unmapped reads zero");
    wr(4'd0, 32'hFFFF_FFFF);
    expect_reg(4'd0, 32'h3F, "R4 control padding zero");
    wr(4'd0, 32'h0);
    wr(4'd7, 32'h0);

    // R2: block compare
    phase = "R2";
    wr(4'd2, 32'h1000_0013); wr(4'd3, 32'h0); wr(4'd4, 32'h0); wr(4'd0, 32'h6);
    acc(32'h1000_0017, 8'h01, 1'b1);
    chk("R2 low bits ignored", {31'h0, brk_req}, 32'h1);
    wr(4'd1, 32'h0);
    acc(32'h1000_0018, 8'hFF, 1'b1);
    chk("R2 next block no hit", {31'h0, brk_req}, 32'h0);
    acc(32'h3000_0010, 8'hFF, 1'b0);
    chk("R2 far block no hit", {31'h0, brk_req}, 32'h0);

    // R3: lane mask
    phase = "R3";
    wr(4'd3, 32'hFFFF_FFFF); wr(4'd4, 32'h00FF_FFFF);
    acc(32'h1000_0010, 8'h0F, 1'b0);
    chk("R3 masked lanes no hit", {31'h0, brk_req}, 32'h0);
    acc(32'h1000_0010, 8'h10, 1'b0);
    chk("R3 offset 4 watched", {31'h0, brk_req}, 32'h1);
    wr(4'd1, 32'h0);
    acc(32'h1000_0010, 8'h20, 1'b0);
    chk("R3 offset 5 ignored", {31'h0, brk_req}, 32'h0);
    wr(4'd3, 32'hFF00_FFFF); wr(4'd4, 32'hFFFF_FFFF);
    acc(32'h1000_0011, 8'h02, 1'b1);
    chk("R3 offset 1 watched", {31'h0, brk_req}, 32'h1);
    wr(4'd1, 32'h0);
    acc(32'h1000_0010, 8'h01, 1'b1);
    chk("R3 offset 0 ignored", {31'h0, brk_req}, 32'h0);
    wr(4'd3, 32'hFF01_FFFF);
    acc(32'h1000_0011, 8'h02, 1'b1);
    chk("R3 nonzero mask byte ignored", {31'h0, brk_req}, 32'h0);
    wr(4'd3, 32'h0); wr(4'd4, 32'h0); wr(4'd1, 32'h0);

    // R4: modes
    phase = "R4";
    wr(4'd0, 32'h2);
    acc(32'h1000_0010, 8'h01, 1'b0);
    chk("R4 write mode ignores read", {31'h0, brk_req}, 32'h0);
    acc(32'h1000_0010, 8'h01, 1'b1);
    chk("R4 write mode hits write", {31'h0, brk_req}, 32'h1);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h4);
    acc(32'h1000_0010, 8'h01, 1'b1);
    chk("R4 read mode ignores write", {31'h0, brk_req}, 32'h0);
    acc(32'h1000_0010, 8'h01, 1'b0);
    chk("R4 read mode hits read", {31'h0, brk_req}, 32'h1);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h1);
    acc(32'h1000_0010, 8'h01, 1'b1);
    chk("R4 mode bit 0 alone inert", {31'h0, brk_req}, 32'h0);
    wr(4'd0, 32'h0);
    acc(32'h1000_0010, 8'h01, 1'b0);
    chk("R4 disabled", {31'h0, brk_req}, 32'h0);
    wr(4'd5, 32'h2000_0000); wr(4'd6, 32'h0); wr(4'd7, 32'h0);
    wr(4'd0, 32'h30);
    acc(32'h2000_0004, 8'h10, 1'b0);
    chk("R4 channel 1 hit", {31'h0, brk_req}, 32'h1);
    expect_reg(4'd1, 32'h20, "R4 channel 1 sets bit 5");
    wr(4'd1, 32'h0);

    // R5: sticky cause
    phase = "R5";
    wr(4'd0, 32'h36);
    acc(32'h1000_0010, 8'h01, 1'b1);
    for (int k = 0; k < 3; k++) expect_reg(4'd1, 32'h10, "R5 cause stays set");

    // R6: cause write
    phase = "R6";
    wr(4'd1, 32'h5);
    expect_reg(4'd1, 32'h5, "R6 write replaces cause");
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h0;
    acc_valid = 1'b1; acc_addr = 32'h1000_0010; acc_be = 8'h01; acc_write = 1'b1;
    tick();
    reg_we = 1'b0; acc_valid = 1'b0;
    expect_reg(4'd1, 32'h10, "R6 hit wins over clear");
    wr(4'd1, 32'h0);
    expect_reg(4'd1, 32'h0, "R6 write zero clears");

    // R7: instruction-break flags
    phase = "R7";
    wr(4'd1, 32'hF);
    chk("R7 no break from flags", {31'h0, brk_req}, 32'h0);
    expect_reg(4'd1, 32'hF, "R7 flags stored");
    wr(4'd1, 32'h0);

    // R8: pulse per hit cycle
    phase = "R8";
    acc_valid = 1'b1; acc_addr = 32'h1000_0010; acc_be = 8'h01; acc_write = 1'b1;
    tick();
    chk("R8 first hit pulse", {31'h0, brk_req}, 32'h1);
    tick();
    chk("R8 second hit pulse", {31'h0, brk_req}, 32'h1);
    acc_valid = 1'b0;
    tick();
    chk("R8 pulse ends", {31'h0, brk_req}, 32'h0);
    wr(4'd1, 32'h0);

    // R9: both channels
    phase = "R9";
    wr(4'd5, 32'h1000_0010);
    acc(32'h1000_0010, 8'h80, 1'b1);
    expect_reg(4'd1, 32'h30, "R9 both cause bits");
    wr(4'd1, 32'h0);

    // R10: valid gating
    phase = "R10";
    acc_valid = 1'b0; acc_addr = 32'h1000_0010; acc_be = 8'hFF; acc_write = 1'b1;
    tick();
    chk("R10 invalid access no hit", {31'h0, brk_req}, 32'h0);
    expect_reg(4'd1, 32'h0, "R10 no cause");

    // R11: same-cycle config write uses old settings
    phase = "R11";
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0;
    acc_valid = 1'b1; acc_addr = 32'h1000_0010; acc_be = 8'h01; acc_write = 1'b0;
    tick();
    reg_we = 1'b0;
    chk("R11 old settings used", {31'h0, brk_req}, 32'h1);
    tick();
    acc_valid = 1'b0;
    chk("R11 new settings after edge", {31'h0, brk_req}, 32'h0);
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule